// File: doc/BRIEF.md
# Polled Slot Bus Device Front-End

This block sits between the serial lines of a dual-path slot bus and the packet layer of one device. A central controller transmits a continuous bit stream on the downstream line. The stream is divided into fixed slots of 288 bits. Each slot begins with a flag-delimited frame. The frame has 21 bytes of content followed by a 16-bit FCS. Byte 0 of the content is a poll number and byte 1 is a destination number. A one-cycle strobe, `bit_en`, marks each bit period. On that strobe the front-end consumes one downstream bit and advances the upstream serializer by one bit.

When the poll byte equals the device's own number and the packet layer is holding a frame, the front-end drives that frame on the upstream line. It starts at a fixed bit count of the slot, so only one device on the bus transmits at a time. The upstream frame is flag-delimited, bit-stuffed and protected by an FCS that the front-end computes. Independently of polling, the receiver accepts a downstream frame when its destination byte equals the device number and its FCS checks good. It then presents the 21 content bytes to the packet layer with a one-cycle strobe. Frames that fail either test are dropped without notice.

Top module: `psb_frontend`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `up_en`, `tx_taken` and `rx_valid` are low.
- R2: A downstream frame with a good FCS whose byte 1 equals `my_id` raises `rx_valid` for exactly one cycle. This is the cycle after the strobe that carries the last bit of the closing flag. `rx_frame` then holds content byte k in bits [8k+7:8k]. Bytes go on the line LSB first, and the FCS is the complemented CRC of polynomial x^16+x^12+x^5+1 with all-ones preset, sent low byte first and LSB first.
- R3: A frame whose byte 1 differs from `my_id` produces no `rx_valid`.
- R4: A frame whose FCS does not check (register residue other than 0xF0B8) produces no `rx_valid`.
- R5: When byte 0 of a slot's frame equals `my_id` and `tx_pending` is high at slot bit 241, `up_en` and a one-cycle `tx_taken` rise in the cycle after the strobe that carries downstream bit 241. Bit 0 is the first bit of the slot's opening flag. After that, `up_data` advances one bit per strobe.
- R6: The upstream frame is the flag 0x7E, then the 168 bits of `tx_frame` LSB first, then the FCS in the R2 format, then a closing 0x7E. A zero is inserted after any five consecutive ones between the flags. `up_en` falls on the strobe after the closing flag's last bit.
- R7: When the device is polled but `tx_pending` is low, `up_en` stays low for the whole slot.
- R8: When byte 0 differs from `my_id`, nothing is transmitted even with `tx_pending` high, and `tx_taken` stays low.
- R9: Device number 0 is reserved. With `my_id` = 0 the front-end neither transmits nor accepts frames.
- R10: The slot bit count restarts at each downstream opening flag. When idle ones precede the flag, the upstream start moves with the flag.
- R11: The receiver removes zeros that were stuffed after five ones, so content bytes of 0xFF are received intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| my_id | input | 8 | Device number (0 = none) |
| bit_en | input | 1 | One-cycle strobe per serial bit period |
| dn_bit | input | 1 | Downstream serial data, sampled on `bit_en` |
| up_data | output | 1 | Upstream serial data |
| up_en | output | 1 | Upstream driver enable |
| tx_pending | input | 1 | Packet layer has a frame ready |
| tx_frame | input | 168 | Frame content to send, byte k at [8k+7:8k] |
| tx_taken | output | 1 | One-cycle pulse: `tx_frame` has been captured |
| rx_valid | output | 1 | One-cycle pulse: accepted frame on `rx_frame` |
| rx_frame | output | 168 | Received frame content, byte k at [8k+7:8k] |

## Verification
Every result is tied to the strobe that causes it. `rx_valid` is due one cycle after the strobe carrying the closing flag's final bit. `up_en` and `tx_taken` are due one cycle after the strobe carrying slot bit 241, and each later upstream bit follows one strobe after the previous one. The bench drives each bit on a falling edge and samples outputs on the next falling edge, after the consuming rising edge. It tags every sample with the index of the downstream bit just consumed, and compares that index against the position computed from its own frame construction. This includes the offset case where idle bits precede the opening flag.

// File: rtl/psb_pkg.sv
package psb_pkg;
  localparam logic [7:0]  FLAG_BYTE = 8'h7E;
  localparam logic [15:0] CRC_POLY_R = 16'h8408;
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;
  localparam logic [15:0] CRC_RESIDUE = 16'hF0B8;
  localparam int          FCS_BITS = 16;
  localparam int          FLAG_BITS = 8;
  localparam int          TAIL_BITS = 6;

  typedef enum logic [1:0] {TX_IDLE, TX_OPEN, TX_BODY, TX_CLOSE} tx_state_e;

  function automatic logic [15:0] crc_bit(input logic [15:0] c, input logic b);
    crc_bit = (c >> 1) ^ (((c[0] ^ b) != 1'b0) ? CRC_POLY_R : 16'h0000);
  endfunction
endpackage

// File: rtl/psb_slot_timer.sv
module psb_slot_timer #(
  parameter int SLOT_BITS = 288,
  parameter int TX_START  = 241
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic realign,
  output logic at_start
);
  import psb_pkg::*;
  localparam int CW = $clog2(SLOT_BITS);

  logic [CW-1:0] cnt;

  assign at_start = bit_en && (cnt == CW'(TX_START));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (bit_en) begin
      if (realign)                        cnt <= CW'(FLAG_BITS);
      else if (cnt == CW'(SLOT_BITS - 1)) cnt <= '0;
      else                                cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/psb_rx_deframer.sv
module psb_rx_deframer #(
  parameter int FRAME_BITS = 168,
  parameter int POLL_IDX   = 0,
  parameter int DEST_IDX   = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bit_en,
  input  logic                  dn_bit,
  input  logic [7:0]            my_id,
  output logic                  open_flag,
  output logic                  poll_hit,
  output logic                  rx_valid,
  output logic [FRAME_BITS-1:0] rx_frame
);
  import psb_pkg::*;
  localparam int BODY = FRAME_BITS + FCS_BITS;
  localparam int PCW  = $clog2(BODY + TAIL_BITS + 2);

  logic [2:0]           ones_q;
  logic                 in_frame;
  logic [PCW-1:0]       pcnt;
  logic [TAIL_BITS-1:0] dly;
  logic [BODY-1:0]      sr;
  logic [15:0]          crc_q;

  logic flag_w, close_w, push, exit_v, id_ok;
  logic [BODY-1:0] sr_nx;

  assign id_ok     = (my_id != 8'd0);
  assign flag_w    = bit_en && !dn_bit && (ones_q == 3'd6);
  assign close_w   = flag_w && in_frame && (pcnt == PCW'(BODY + TAIL_BITS));
  assign open_flag = flag_w && !close_w;
  assign push      = bit_en && in_frame && (ones_q < 3'd5);
  assign exit_v    = push && (pcnt >= PCW'(TAIL_BITS));
  assign sr_nx     = {dly[0], sr[BODY-1:1]};
  assign poll_hit  = exit_v && id_ok
                   && (pcnt == PCW'(TAIL_BITS + 8*POLL_IDX + 7))
                   && (sr_nx[BODY-1 -: 8] == my_id);

  always_ff @(posedge clk) begin
    if (rst) begin
      ones_q   <= '0;
      in_frame <= 1'b0;
      pcnt     <= '0;
      dly      <= '0;
      sr       <= '0;
      crc_q    <= CRC_PRESET;
      rx_valid <= 1'b0;
      rx_frame <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (bit_en) begin
        ones_q <= dn_bit ? ((ones_q == 3'd7) ? 3'd7 : ones_q + 3'd1) : 3'd0;
        if (open_flag) begin
          in_frame <= 1'b1;
          pcnt     <= '0;
          crc_q    <= CRC_PRESET;
        end else if (close_w) begin
          in_frame <= 1'b0;
          if (crc_q == CRC_RESIDUE && id_ok && sr[8*DEST_IDX +: 8] == my_id) begin
            rx_valid <= 1'b1;
            rx_frame <= sr[FRAME_BITS-1:0];
          end
        end else if (in_frame && dn_bit && ones_q >= 3'd6) begin
          in_frame <= 1'b0;
        end else if (push && pcnt == PCW'(BODY + TAIL_BITS)) begin
          in_frame <= 1'b0;
        end else if (push) begin
          dly  <= {dn_bit, dly[TAIL_BITS-1:1]};
          pcnt <= pcnt + 1'b1;
          if (exit_v) begin
            sr    <= sr_nx;
            crc_q <= crc_bit(crc_q, dly[0]);
          end
        end
      end
    end
  end
endmodule

// File: rtl/psb_tx_framer.sv
module psb_tx_framer #(
  parameter int FRAME_BITS = 168
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bit_en,
  input  logic                  at_start,
  input  logic                  open_flag,
  input  logic                  poll_hit,
  input  logic                  tx_pending,
  input  logic [FRAME_BITS-1:0] tx_frame,
  output logic                  up_data,
  output logic                  up_en,
  output logic                  tx_taken
);
  import psb_pkg::*;
  localparam int BODY = FRAME_BITS + FCS_BITS;
  localparam int IW   = $clog2(BODY + 1);

  tx_state_e             st;
  logic                  polled;
  logic [IW-1:0]         idx;
  logic [2:0]            ones;
  logic [FRAME_BITS-1:0] sh;
  logic [15:0]           crc_q;
  logic                  go, bit_w;

  assign go    = at_start && polled && tx_pending && (st == TX_IDLE);
  assign bit_w = (idx < IW'(FRAME_BITS)) ? sh[0] : ~crc_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= TX_IDLE;
      polled   <= 1'b0;
      idx      <= '0;
      ones     <= '0;
      sh       <= '0;
      crc_q    <= CRC_PRESET;
      up_data  <= 1'b0;
      up_en    <= 1'b0;
      tx_taken <= 1'b0;
    end else begin
      tx_taken <= 1'b0;
      if (at_start || open_flag) polled <= 1'b0;
      else if (poll_hit)         polled <= 1'b1;
      if (bit_en) begin
        case (st)
          TX_IDLE: if (go) begin
            st       <= TX_OPEN;
            up_en    <= 1'b1;
            up_data  <= FLAG_BYTE[0];
            idx      <= IW'(1);
            sh       <= tx_frame;
            crc_q    <= CRC_PRESET;
            ones     <= '0;
            tx_taken <= 1'b1;
          end
          TX_OPEN: begin
            up_data <= FLAG_BYTE[idx[2:0]];
            if (idx == IW'(FLAG_BITS - 1)) begin
              st  <= TX_BODY;
              idx <= '0;
            end else begin
              idx <= idx + 1'b1;
            end
          end
          TX_BODY: begin
            if (ones == 3'd5) begin
              up_data <= 1'b0;
              ones    <= '0;
            end else if (idx == IW'(BODY)) begin
              up_data <= FLAG_BYTE[0];
              st      <= TX_CLOSE;
              idx     <= IW'(1);
            end else begin
              up_data <= bit_w;
              ones    <= bit_w ? ones + 3'd1 : 3'd0;
              idx     <= idx + 1'b1;
              if (idx < IW'(FRAME_BITS)) begin
                sh    <= sh >> 1;
                crc_q <= crc_bit(crc_q, sh[0]);
              end else begin
                crc_q <= crc_q >> 1;
              end
            end
          end
          TX_CLOSE: begin
            if (idx == IW'(FLAG_BITS)) begin
              up_en <= 1'b0;
              st    <= TX_IDLE;
              idx   <= '0;
            end else begin
              up_data <= FLAG_BYTE[idx[2:0]];
              idx     <= idx + 1'b1;
            end
          end
          default: st <= TX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/psb_frontend.sv
module psb_frontend #(
  parameter int SLOT_BITS  = 288,
  parameter int TX_START   = 241,
  parameter int CTRL_BYTES = 5,
  parameter int DATA_BYTES = 16,
  parameter int POLL_IDX   = 0,
  parameter int DEST_IDX   = 1,
  localparam int FRAME_BITS = 8 * (CTRL_BYTES + DATA_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [7:0]            my_id,
  input  logic                  bit_en,
  input  logic                  dn_bit,
  output logic                  up_data,
  output logic                  up_en,
  input  logic                  tx_pending,
  input  logic [FRAME_BITS-1:0] tx_frame,
  output logic                  tx_taken,
  output logic                  rx_valid,
  output logic [FRAME_BITS-1:0] rx_frame
);
  logic open_flag, poll_hit, at_start;

  psb_slot_timer #(.SLOT_BITS(SLOT_BITS), .TX_START(TX_START)) timer_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .realign(open_flag), .at_start(at_start)
  );

  psb_rx_deframer #(.FRAME_BITS(FRAME_BITS), .POLL_IDX(POLL_IDX), .DEST_IDX(DEST_IDX)) rx_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .dn_bit(dn_bit), .my_id(my_id),
    .open_flag(open_flag), .poll_hit(poll_hit), .rx_valid(rx_valid), .rx_frame(rx_frame)
  );

  psb_tx_framer #(.FRAME_BITS(FRAME_BITS)) tx_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .at_start(at_start), .open_flag(open_flag),
    .poll_hit(poll_hit), .tx_pending(tx_pending), .tx_frame(tx_frame),
    .up_data(up_data), .up_en(up_en), .tx_taken(tx_taken)
  );
endmodule

// File: rtl/psb_checker.sv
module psb_checker #(
  parameter int FRAME_BITS = 168,
  parameter int DEST_IDX   = 1
) (
  input logic                  clk,
  input logic                  rst,
  input logic [7:0]            my_id,
  input logic                  bit_en,
  input logic                  tx_pending,
  input logic                  up_data,
  input logic                  up_en,
  input logic                  tx_taken,
  input logic                  rx_valid,
  input logic [FRAME_BITS-1:0] rx_frame
);
  // R5: upstream enable only rises on a bit strobe
  p_start_on_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(up_en) |-> $past(bit_en));
  // R5: capture pulse coincides with the first flag bit
  p_taken_with_flag_r5: assert property (@(posedge clk) disable iff (rst)
    tx_taken |-> (up_en && !up_data && !$past(up_en)));
  // R6: upstream line only moves on strobes
  p_hold_between_strobes_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(bit_en) |-> ($stable(up_en) && $stable(up_data)));
  // R8: nothing is taken without a request
  p_taken_needs_request_r8: assert property (@(posedge clk) disable iff (rst)
    tx_taken |-> $past(tx_pending));
  // R2: accept strobe lasts one cycle
  p_rx_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
  // R2: received content only changes with an accept strobe
  p_frame_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_frame) |-> rx_valid);
  // R3: accepted frame carries this device number
  p_dest_match_r3: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (rx_frame[8*DEST_IDX +: 8] == my_id));
  // R9: reserved number is silent
  p_id0_silent_r9: assert property (@(posedge clk) disable iff (rst)
    (my_id == 8'd0 && $past(my_id) == 8'd0) |-> (!rx_valid && !tx_taken));
endmodule

bind psb_frontend psb_checker #(.FRAME_BITS(FRAME_BITS), .DEST_IDX(DEST_IDX)) chk_i (.*);

// File: tb/psb_frontend_tb_top.sv
module psb_frontend_tb_top;
  localparam int FB = 168;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] my_id = 8'h5A;
  logic bit_en = 1'b0, dn_bit = 1'b1, tx_pending = 1'b0;
  logic [FB-1:0] tx_frame = '0;
  logic up_data, up_en, tx_taken, rx_valid;
  logic [FB-1:0] rx_frame;

  always #4 clk = ~clk;

  psb_frontend dut_i (
    .clk(clk), .rst(rst), .my_id(my_id), .bit_en(bit_en), .dn_bit(dn_bit),
    .up_data(up_data), .up_en(up_en), .tx_pending(tx_pending), .tx_frame(tx_frame),
    .tx_taken(tx_taken), .rx_valid(rx_valid), .rx_frame(rx_frame)
  );

  int checks = 0, fails = 0;
  logic stream [0:1023];
  int slen, flag_end;
  logic cap [0:1023];
  int capn, first_en, gbit, rxv_cnt, rxv_at, tk_cnt, tk_at, en_cnt;
  logic [FB-1:0] rxv_data;

  task automatic check(input bit ok, input string tag, input logic [FB-1:0] act, input logic [FB-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] bcrc(input logic [15:0] c, input logic b);
    bcrc = (c >> 1) ^ (((c[0] ^ b) != 1'b0) ? 16'h8408 : 16'h0000);
  endfunction

  function automatic logic [FB-1:0] mkframe(input logic [7:0] poll, input logic [7:0] dest,
                                            input int seed, input bit ones_fill);
    logic [FB-1:0] f;
    f = '0;
    f[7:0] = poll;
    f[15:8] = dest;
    for (int k = 2; k < FB/8; k++) f[8*k +: 8] = ones_fill ? 8'hFF : 8'((seed * 37) + (k * 29));
    return f;
  endfunction

  task automatic put(input logic b);
    stream[slen] = b;
    slen++;
  endtask

  task automatic put_flag();
    logic [7:0] f = 8'h7E;
    for (int k = 0; k < 8; k++) put(f[k]);
  endtask

  task automatic put_body(input logic b, inout int ones);
    put(b);
    ones = b ? ones + 1 : 0;
    if (ones == 5) begin
      put(1'b0);
      ones = 0;
    end
  endtask

  task automatic build_slot(input int pre, input logic [FB-1:0] fr, input bit bad);
    int ones = 0;
    logic [15:0] c = 16'hFFFF;
    logic [15:0] fcs;
    slen = 0;
    repeat (pre) put(1'b1);
    put_flag();
    for (int k = 0; k < FB; k++) begin
      c = bcrc(c, fr[k]);
      put_body(fr[k], ones);
    end
    fcs = ~c;
    if (bad) fcs[3] = ~fcs[3];
    for (int k = 0; k < 16; k++) put_body(fcs[k], ones);
    put_flag();
    flag_end = slen - 1;
    while (slen < pre + 288) put(1'b1);
  endtask

  task automatic reset_mon();
    capn = 0; first_en = -1; gbit = 0; rxv_cnt = 0; rxv_at = -1;
    tk_cnt = 0; tk_at = -1; en_cnt = 0; rxv_data = '0;
  endtask

  task automatic drive();
    for (int i = 0; i < slen; i++) begin
      @(negedge clk);
      bit_en = 1'b1;
      dn_bit = stream[i];
      @(negedge clk);
      bit_en = 1'b0;
      if (up_en) begin
        cap[capn] = up_data;
        capn++;
        en_cnt++;
        if (first_en < 0) first_en = gbit;
      end
      if (tx_taken) begin
        tk_cnt++;
        tk_at = gbit;
        tx_pending = 1'b0;
      end
      if (rx_valid) begin
        rxv_cnt++;
        rxv_at = gbit;
        rxv_data = rx_frame;
      end
      gbit++;
    end
  endtask

  task automatic filler();
    build_slot(0, mkframe(8'h01, 8'h02, 99, 1'b0), 1'b0);
    drive();
  endtask

  task automatic check_up(input logic [FB-1:0] exp, input string tag);
    logic [7:0] f = 8'h7E;
    logic body [0:255];
    int n = 0, ones = 0, j = 8;
    bit done = 0, flag_ok = 1;
    logic [15:0] c = 16'hFFFF;
    logic [FB-1:0] got = '0;
    for (int k = 0; k < 8; k++) if (cap[k] !== f[k]) flag_ok = 0;
    check(flag_ok, {tag, " R6 opening flag"}, FB'(flag_ok), FB'(1));
    while (j < capn && !done) begin
      if (ones == 5) begin
        if (cap[j] == 1'b0) ones = 0;
        else done = 1;
      end else begin
        if (n < 256) body[n] = cap[j];
        n++;
        ones = cap[j] ? ones + 1 : 0;
      end
      j++;
    end
    n = n - 6;
    check(n == 184, {tag, " R6 body length"}, FB'(n), FB'(184));
    check(capn == j + 1 && cap[capn-1] == 1'b0, {tag, " R6 closing flag and end"}, FB'(capn), FB'(j + 1));
    if (n == 184) begin
      for (int k = 0; k < 184; k++) c = bcrc(c, body[k]);
      for (int k = 0; k < FB; k++) got[k] = body[k];
      check(got == exp, {tag, " R6 content"}, got, exp);
      check(c == 16'hF0B8, {tag, " R6 fcs residue"}, FB'(c), FB'(16'hF0B8));
    end
  endtask

  task automatic t_reset();
    check(!up_en && !tx_taken && !rx_valid, "R1 reset outputs", FB'({up_en, tx_taken, rx_valid}), FB'(0));
  endtask

  task automatic t_rx(input logic [7:0] dest, input bit bad, input bit fill, input bit expect_ok, input string tag);
    logic [FB-1:0] fr = mkframe(8'h11, dest, 3, fill);
    reset_mon();
    build_slot(0, fr, bad);
    drive();
    check(rxv_cnt == (expect_ok ? 1 : 0), {tag, " accept count"}, FB'(rxv_cnt), FB'(expect_ok ? 1 : 0));
    if (expect_ok) begin
      check(rxv_at == flag_end, {tag, " accept timing"}, FB'(rxv_at), FB'(flag_end));
      check(rxv_data == fr, {tag, " content"}, rxv_data, fr);
    end
    check(en_cnt == 0, {tag, " R8 no upstream"}, FB'(en_cnt), FB'(0));
  endtask

  task automatic t_tx(input int pre, input bit fill, input string tag);
    logic [FB-1:0] payload = mkframe(8'hC3, 8'h3C, 11 + pre, fill);
    reset_mon();
    tx_frame = payload;
    tx_pending = 1'b1;
    build_slot(pre, mkframe(8'h5A, 8'h44, 5, 1'b0), 1'b0);
    drive();
    tx_frame = '0;
    filler();
    check(first_en == pre + 241, {tag, " R5 start position"}, FB'(first_en), FB'(pre + 241));
    check(tk_cnt == 1 && tk_at == pre + 241, {tag, " R5 taken pulse"}, FB'(tk_at), FB'(pre + 241));
    check_up(payload, tag);
  endtask

  task automatic t_silent(input logic [7:0] id, input logic [7:0] poll, input logic [7:0] dest,
                          input bit pend, input string tag);
    my_id = id;
    reset_mon();
    tx_frame = mkframe(8'h00, 8'h00, 77, 1'b0);
    tx_pending = pend;
    build_slot(0, mkframe(poll, dest, 8, 1'b0), 1'b0);
    drive();
    filler();
    check(en_cnt == 0 && tk_cnt == 0, {tag, " no upstream"}, FB'(en_cnt), FB'(0));
    check(rxv_cnt == 0, {tag, " no accept"}, FB'(rxv_cnt), FB'(0));
    tx_pending = 1'b0;
    my_id = 8'h5A;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    filler();
    t_rx(8'h5A, 1'b0, 1'b0, 1'b1, "R2 matching frame");
    t_rx(8'h33, 1'b0, 1'b0, 1'b0, "R3 other destination");
    t_rx(8'h5A, 1'b1, 1'b0, 1'b0, "R4 bad fcs");
    t_rx(8'h5A, 1'b0, 1'b1, 1'b1, "R11 stuffed ones");
    t_tx(0, 1'b0, "R5 polled send");
    t_tx(0, 1'b1, "R6 stuffed send");
    t_silent(8'h5A, 8'h5A, 8'h44, 1'b0, "R7 polled idle");
    t_silent(8'h5A, 8'h11, 8'h44, 1'b1, "R8 not polled");
    t_silent(8'h00, 8'h00, 8'h00, 1'b1, "R9 reserved id");
    t_tx(37, 1'b0, "R10 realigned slot");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule